// File: doc/BRIEF.md
# Modular-Metric Add-Compare-Select Array

This block keeps the path metrics of a rate-1/2 hard-decision Viterbi decoder with 2^M trellis states, where M is the code memory (default 2, constraint length 3). Each accepted input is one received bit pair. For every transition the block forms a Hamming branch metric against the encoder output that its generator polynomials give. For every next state it then adds, compares and selects between the two predecessor candidates. Per accepted pair it registers one decision bit per state and the index of the state with the best metric.

The metric registers are narrow and wrap freely in two's-complement arithmetic. A comparison takes the difference of two metrics at register width and reads its sign. Because the spread between live metrics stays below half the modular range, the selections are exactly those that unbounded integer metrics would give, and no renormalization step is ever needed. The register width is derived from the largest branch metric (2) and the code memory. Survivor storage and traceback belong to a separate block that consumes the decision bits and the best-state index.

Top module: `acs_modular`

## Requirements
- R1: While reset is asserted, and after it is released, dec_valid, dec_bits and best_state are 0. State 0 starts with metric 0 and every other state starts with metric 2·M.
- R2: For the transition from predecessor p with input bit u, the encoder register is {u, p}, a vector of M+1 bits with u as its most significant bit. The expected pair is in_sym[0] = parity(register AND G0) and in_sym[1] = parity(register AND G1). The branch metric is the Hamming distance (0 to 2) between in_sym and that expected pair.
- R3: For next state j, the predecessors are p0 = (j<<1) & (2^M−1) and p1 = p0|1, and the input bit is u = bit M−1 of j. The new metric is the smaller of the two candidates metric(p)+branch metric. dec_bits[j] is the least significant bit of the winning predecessor's index.
- R4: When both candidates of a state are equal, predecessor p0 wins and dec_bits[j] is 0.
- R5: dec_valid is 1 in exactly the cycle after a cycle with in_valid high. dec_bits and best_state are updated at that same clock edge.
- R6: With in_valid low the metrics do not change, dec_valid is 0, and dec_bits and best_state hold their values.
- R7: best_state is the index of the state with the smallest updated metric, with the lowest index winning a tie.
- R8: Over arbitrarily long input streams the decisions and best_state are identical to those of an unbounded-integer reference, even though the stored metrics wrap.
- R9: For a noise-free codeword that starts from state 0, best_state follows the encoder state, where the encoder state after input u is (u<<(M−1)) | (previous state>>1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The received pair on in_sym is accepted this cycle |
| in_sym | input | 2 | Received hard-decision pair: bit 0 is matched against G0, bit 1 against G1 |
| dec_valid | output | 1 | dec_bits and best_state belong to the pair accepted one cycle earlier |
| dec_bits | output | 2^M | Per-state decision: the least significant bit of the winning predecessor |
| best_state | output | M | Index of the state with the smallest metric |

## Verification
The hardest situation to reach is one where the stored metrics have wrapped many times and a selection still depends on the sign of a wrapped difference. A short directed sequence never gets there. The bench therefore drives several thousand encoded pairs with randomly flipped bits, and compares every decision and best-state index against an unbounded-integer model. Exact ties are equally hard to hit on purpose. They are produced by sending a pair right after reset, when two predecessors that share the same starting offset meet at equal distance.

// File: rtl/acs_modular.sv
module acs_modular #(
  parameter int M  = 2,
  parameter int G0 = 7,
  parameter int G1 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_sym,
  output logic                dec_valid,
  output logic [(1<<M)-1:0]   dec_bits,
  output logic [M-1:0]        best_state
);
  localparam int NS       = 1 << M;
  localparam int MASK     = NS - 1;
  localparam int MW       = $clog2(4 * M) + 2;
  localparam int INIT_OFS = 2 * M;
  localparam int RMASK    = (2 << M) - 1;

  function automatic logic [1:0] expect_pair(input int u, input int p);
    int r;
    r = (u << M) | p;
    return {^(r & G1 & RMASK), ^(r & G0 & RMASK)};
  endfunction

  logic [MW-1:0]   pm    [NS];
  logic [MW-1:0]   pm_nx [NS];
  logic [NS-1:0]   dec_nx;
  logic [NS*MW-1:0] pm_flat;

  for (genvar j = 0; j < NS; j++) begin : g_acs
    localparam int P0 = (j << 1) & MASK;
    localparam int P1 = P0 | 1;
    localparam int U  = j >> (M - 1);
    localparam logic [1:0] E0 = expect_pair(U, P0);
    localparam logic [1:0] E1 = expect_pair(U, P1);
    wire [1:0]    x0 = in_sym ^ E0;
    wire [1:0]    x1 = in_sym ^ E1;
    wire [MW-1:0] c0 = pm[P0] + MW'(x0[0]) + MW'(x0[1]);
    wire [MW-1:0] c1 = pm[P1] + MW'(x1[0]) + MW'(x1[1]);
    wire [MW-1:0] d  = c1 - c0;
    assign dec_nx[j] = d[MW-1];
    assign pm_nx[j]  = d[MW-1] ? c1 : c0;
    assign pm_flat[j*MW +: MW] = pm[j];
  end

  logic [MW-1:0] tm [2*NS-1];
  logic [M-1:0]  ti [2*NS-1];

  for (genvar k = 0; k < NS; k++) begin : g_leaf
    assign tm[NS-1+k] = pm_nx[k];
    assign ti[NS-1+k] = M'(k);
  end

  for (genvar n = 0; n < NS - 1; n++) begin : g_node
    wire [MW-1:0] dd = tm[2*n+2] - tm[2*n+1];
    assign tm[n] = dd[MW-1] ? tm[2*n+2] : tm[2*n+1];
    assign ti[n] = dd[MW-1] ? ti[2*n+2] : ti[2*n+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) pm[k] <= (k == 0) ? '0 : MW'(INIT_OFS);
      dec_valid  <= 1'b0;
      dec_bits   <= '0;
      best_state <= '0;
    end else begin
      dec_valid <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < NS; k++) pm[k] <= pm_nx[k];
        dec_bits   <= dec_nx;
        best_state <= ti[0];
      end
    end
  end
endmodule

module acs_modular_chk #(
  parameter int M  = 2,
  parameter int MW = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   dec_valid,
  input logic [(1<<M)-1:0]      dec_bits,
  input logic [M-1:0]           best_state,
  input logic [(1<<M)*MW-1:0]   pm_flat
);
  localparam int NS    = 1 << M;
  localparam int BOUND = 1 << (MW - 2);

  function automatic logic best_is_min(input logic [NS*MW-1:0] f, input logic [M-1:0] b);
    logic [MW-1:0] d;
    for (int k = 0; k < NS; k++) begin
      d = f[k*MW +: MW] - f[int'(b)*MW +: MW];
      if (d[MW-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic spread_ok(input logic [NS*MW-1:0] f);
    logic [MW-1:0] d;
    for (int k = 0; k < NS; k++)
      for (int i = 0; i < NS; i++) begin
        d = f[k*MW +: MW] - f[i*MW +: MW];
        if (!d[MW-1] && int'(d) >= BOUND) return 1'b0;
      end
    return 1'b1;
  endfunction

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dec_valid);
  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dec_valid);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dec_bits) && $stable(best_state) && $stable(pm_flat)));
  p_best_is_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> best_is_min(pm_flat, best_state));
  p_spread_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spread_ok(pm_flat));
endmodule

bind acs_modular acs_modular_chk #(.M(M), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_valid(dec_valid),
  .dec_bits(dec_bits), .best_state(best_state), .pm_flat(pm_flat)
);

// File: tb/acs_modular_bench.sv
module acs_modular_bench;
  localparam int M  = 2;
  localparam int NS = 1 << M;
  localparam int G0 = 7;
  localparam int G1 = 5;

  // {in_sym, expected best_state}: noise-free code for inputs 1,0,1,1,0,0
  localparam logic [3:0] VEC [6] = '{
    {2'b11, 2'd2}, {2'b01, 2'd1}, {2'b00, 2'd2},
    {2'b10, 2'd3}, {2'b10, 2'd1}, {2'b11, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_sym = 2'b00;
  logic dec_valid;
  logic [NS-1:0] dec_bits;
  logic [M-1:0] best_state;

  int n_chk = 0;
  int n_err = 0;
  int rm [NS];
  int exp_dec;
  int exp_best;

  always #4 clk = ~clk;

  acs_modular #(.M(M), .G0(G0), .G1(G1)) u_acs_modular (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .dec_valid(dec_valid), .dec_bits(dec_bits), .best_state(best_state)
  );

  function automatic int enc(input int u, input int p);
    int r;
    r = (u << M) | p;
    return ($countones(r & G1) % 2) * 2 + ($countones(r & G0) % 2);
  endfunction

  function automatic int ham(input int a, input int b);
    return $countones((a ^ b) & 3);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic ref_reset();
    for (int k = 0; k < NS; k++) rm[k] = (k == 0) ? 0 : 2 * M;
  endtask

  task automatic ref_update(input int s);
    int nm [NS];
    exp_dec = 0;
    for (int j = 0; j < NS; j++) begin
      int p0, u, a, b;
      p0 = (j << 1) & (NS - 1);
      u  = j >> (M - 1);
      a  = rm[p0] + ham(s, enc(u, p0));
      b  = rm[p0 | 1] + ham(s, enc(u, p0 | 1));
      if (b < a) begin nm[j] = b; exp_dec |= (1 << j); end
      else nm[j] = a;
    end
    exp_best = 0;
    for (int k = 0; k < NS; k++) begin
      rm[k] = nm[k];
      if (nm[k] < nm[exp_best]) exp_best = k;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ref_reset();
  endtask

  task automatic step(input logic v, input logic [1:0] s);
    @(negedge clk); in_valid = v; in_sym = s;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (v) ref_update(int'(s));
  endtask

  task automatic chk_ref(input string req);
    chk({req, " dec_valid"}, int'(dec_valid), 1);
    chk({req, " dec_bits"}, int'(dec_bits), exp_dec);
    chk({req, " best_state"}, int'(best_state), exp_best);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int st, hb, hd;
    void'($urandom(31));
    ref_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset dec_valid", int'(dec_valid), 0);
    chk("R1 reset dec_bits", int'(dec_bits), 0);
    chk("R1 reset best_state", int'(best_state), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release best_state", int'(best_state), 0);

    // R4: two offset predecessors meet at equal cost on the first pair
    step(1'b1, 2'b00);
    chk("R4 tie to p0 dec_bits", int'(dec_bits), 0);
    chk_ref("R3 first pair");
    do_reset();
    step(1'b1, 2'b11);
    chk("R4 tie on 11 dec_bits[1]", int'(dec_bits[1]), 0);
    chk_ref("R2 first pair 11");

    // R9 / R2 table walk
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(1'b1, VEC[i][3:2]);
      chk("R9 best follows encoder", int'(best_state), int'(VEC[i][1:0]));
      chk_ref("R7 table");
    end

    // R6 idle: outputs and metrics hold
    hb = int'(best_state); hd = int'(dec_bits);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 2'(i));
      chk("R6 idle dec_valid", int'(dec_valid), 0);
      chk("R6 idle dec_bits hold", int'(dec_bits), hd);
      chk("R6 idle best hold", int'(best_state), hb);
    end
    step(1'b1, 2'b01);
    chk_ref("R6 metrics unchanged by idle");
    step(1'b1, 2'b10);
    chk_ref("R5 back-to-back");

    // R8 long noisy stream, metrics wrap many times
    do_reset();
    st = 0;
    for (int i = 0; i < 4000; i++) begin
      int u, s;
      u = int'($urandom % 2);
      s = enc(u, st);
      if ($urandom % 5 == 0) s ^= 1;
      if ($urandom % 7 == 0) s ^= 2;
      st = (u << (M - 1)) | (st >> 1);
      step(1'b1, 2'(s));
      chk_ref("R8 wrapped metrics");
      if (i % 500 == 499) begin
        step(1'b0, 2'b00);
        chk("R5 dec_valid drops", int'(dec_valid), 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule